// File: doc/BRIEF.md
# Prescaled Real-Time Counter Core

This block keeps time from a slow reference clock. It has two counting stages. A 15-bit pre-counter advances on every running clock. A 32-bit main counter advances in one of two ways. In divider mode it steps on a power-of-two prescaler tick. In match mode it steps in each cycle where the pre-counter equals an external reference value. Each stage can also be told to wrap at an external compare value instead of running through its full range.

Software drives the block through one write port. The port selects a control word, the pre-counter, the main counter or a lock register. Writing a lock key freezes the first three targets, and only a separate unlock key frees them again. A combined 32-bit read view packs the low main-counter bits over the pre-counter. A debug-halt input can freeze both stages, unless the control word asks the block to keep running. The write port and the compare inputs are plain control pins. The block never back-pressures a write: every write takes effect at the clock edge where `wr_en` is high.

Top module: `rtc_core`

## Requirements
- R1: Control bits [11:8] hold a divider select n from 0 to 15. In divider mode (control bit 4 = 0), the main counter rises by exactly one per 2^n running cycles. After N running edges from a cleared divider, it has risen by N>>n.
- R2: While running, the pre-counter rises by one every clock. Without pre-wrap it rolls from 0x7FFF to 0.
- R3: In match mode (control bit 4 = 1), the main counter rises by one at the edge where the pre-counter equals `match_ref`, and at no other edge.
- R4: With pre-wrap enabled (control bit 2), the pre-counter goes to 0 at the edge after it equals `match_ref`, instead of incrementing.
- R5: With main-wrap enabled (control bit 3), the main counter goes to 0 at a step taken while it equals `wrap_ref`.
- R6: `comb_view` equals main-counter bits [16:0] placed above pre-counter bits [14:0].
- R7: `wr_sel` encodes 0 = control, 1 = pre-counter, 2 = main counter, 3 = lock. Writing 0x4C4F434B to the lock register engages the lock and writing 0x554E4C4B releases it. Any other value leaves the lock as it is. While locked, writes to control, pre-counter and main counter are ignored. `locked` shows the lock state.
- R8: Control bit 1 is debug-run. While `dbg_halt` is high and debug-run is 0, both counters hold. With debug-run at 1, counting goes on.
- R9: A write to either counter takes priority over an increment in the same cycle. The written value appears after that edge.
- R10: While the enable bit (control bit 0) is 0, both counters hold their values.
- R11: The prescaler divider clears when a control write changes the divider select, and it stays clear while the block is disabled.
- R12: After reset, both counters are 0, the control word is 0 and the lock is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 pre-counter, 2 main counter, 3 lock |
| wr_data | input | 32 | Write data |
| match_ref | input | 15 | Pre-counter compare value (match tick and pre-wrap) |
| wrap_ref | input | 32 | Main-counter wrap value |
| dbg_halt | input | 1 | Debug halt request |
| pre_cnt | output | 15 | Pre-counter value |
| main_cnt | output | 32 | Main counter value |
| comb_view | output | 32 | Combined view {main[16:0], pre[14:0]} |
| locked | output | 1 | Lock engaged |

## Verification
Assertions check several rules on every cycle:
- a counter write lands ahead of any increment;
- a disabled or halted core holds both counters;
- a locked core keeps its control word;
- a wrapping stage lands on zero;
- the divider never exceeds its selected terminal count.

Other behaviour only the bench can show. This covers the exact division ratio for every select value, the pre-counter rollover, the match-mode period, the divider clearing when the select changes, and the packing of the combined view. The bench sweeps all sixteen divider selects and compares the counts against arithmetic expectations.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam logic [31:0] KEY_ENGAGE  = 32'h4C4F_434B;
  localparam logic [31:0] KEY_RELEASE = 32'h554E_4C4B;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_PRE  = 2'd1,
    SEL_MAIN = 2'd2,
    SEL_LOCK = 2'd3
  } wsel_e;

  typedef struct packed {
    logic [3:0] div_sel;
    logic       match_mode;
    logic       main_wrap;
    logic       pre_wrap;
    logic       dbg_run;
    logic       enable;
  } ctrl_t;

  function automatic ctrl_t ctrl_unpack(input logic [31:0] w);
    ctrl_t c;
    c.enable     = w[0];
    c.dbg_run    = w[1];
    c.pre_wrap   = w[2];
    c.main_wrap  = w[3];
    c.match_mode = w[4];
    c.div_sel    = w[11:8];
    return c;
  endfunction

endpackage

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  output ctrl_t       ctrl,
  output logic        locked,
  output logic        pre_load,
  output logic        main_load,
  output logic        div_clr
);

  wsel_e sel;
  ctrl_t ctrl_new;
  logic  ctrl_wr;
  logic  lock_wr;
  logic  unused_bits;

  assign sel         = wsel_e'(wr_sel);
  assign ctrl_new    = ctrl_unpack(wr_data);
  assign unused_bits = ^{wr_data[31:12], wr_data[7:5]};

  assign ctrl_wr   = wr_en && !locked && (sel == SEL_CTRL);
  assign pre_load  = wr_en && !locked && (sel == SEL_PRE);
  assign main_load = wr_en && !locked && (sel == SEL_MAIN);
  assign lock_wr   = wr_en && (sel == SEL_LOCK);
  assign div_clr   = ctrl_wr && (ctrl_new.div_sel != ctrl.div_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      locked <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl <= ctrl_new;
      if (lock_wr) begin
        if (wr_data == KEY_ENGAGE)       locked <= 1'b1;
        else if (wr_data == KEY_RELEASE) locked <= 1'b0;
      end
    end
  end

  // R7: a locked core keeps its control word
  a_r7_ctrl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !lock_wr) |=> (ctrl == $past(ctrl)));

  // R7: only the two keys move the lock
  a_r7_lock_keys: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_wr || (wr_data != KEY_ENGAGE && wr_data != KEY_RELEASE))
      |=> (locked == $past(locked)));

endmodule

// File: rtl/rtc_presc.sv
module rtc_presc #(
  parameter int DW = 15,
  localparam int SW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic [SW-1:0] sel,
  output logic          tick
);

  logic [DW-1:0] div_q;
  logic [DW-1:0] term;

  assign term = ~({DW{1'b1}} << sel);
  assign tick = run && (div_q == term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     div_q <= '0;
    else if (clr)   div_q <= '0;
    else if (tick)  div_q <= '0;
    else if (run)   div_q <= div_q + 1'b1;
  end

  // R1: the divider stays within the selected terminal count
  a_r1_div_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    div_q <= term);

  // R11: a clear request leaves the divider at zero
  a_r11_div_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (div_q == '0));

endmodule

// File: rtl/rtc_stage.sv
module rtc_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  input  logic         wrap_en,
  input  logic [W-1:0] cmp,
  output logic [W-1:0] q,
  output logic         hit
);

  assign hit = (q == cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              q <= '0;
    else if (load)           q <= load_val;
    else if (inc) begin
      if (wrap_en && hit)    q <= '0;
      else                   q <= q + 1'b1;
    end
  end

  // R9: a load beats a simultaneous increment
  a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(load_val)));

  // R4 / R5: a wrapping step lands on zero
  a_r5_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && inc && wrap_en && hit) |=> (q == '0));

endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int PW = 15,
  parameter int CW = 32,
  localparam int SW = $clog2(PW + 1),
  localparam int HW = CW - PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [CW-1:0] wr_data,
  input  logic [PW-1:0] match_ref,
  input  logic [CW-1:0] wrap_ref,
  input  logic          dbg_halt,
  output logic [PW-1:0] pre_cnt,
  output logic [CW-1:0] main_cnt,
  output logic [CW-1:0] comb_view,
  output logic          locked
);

  ctrl_t ctrl;
  logic  pre_load, main_load, div_clr_wr;
  logic  run, presc_tick, pre_hit, main_hit, main_step;

  rtc_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .ctrl      (ctrl),
    .locked    (locked),
    .pre_load  (pre_load),
    .main_load (main_load),
    .div_clr   (div_clr_wr)
  );

  assign run = ctrl.enable && (!dbg_halt || ctrl.dbg_run);

  rtc_presc #(.DW(PW)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (div_clr_wr || !ctrl.enable),
    .run   (run),
    .sel   (SW'(ctrl.div_sel)),
    .tick  (presc_tick)
  );

  rtc_stage #(.W(PW)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (pre_load),
    .load_val (wr_data[PW-1:0]),
    .inc      (run),
    .wrap_en  (ctrl.pre_wrap),
    .cmp      (match_ref),
    .q        (pre_cnt),
    .hit      (pre_hit)
  );

  assign main_step = ctrl.match_mode ? (run && pre_hit) : presc_tick;

  rtc_stage #(.W(CW)) u_main (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (main_load),
    .load_val (wr_data),
    .inc      (main_step),
    .wrap_en  (ctrl.main_wrap),
    .cmp      (wrap_ref),
    .q        (main_cnt),
    .hit      (main_hit)
  );

  assign comb_view = {main_cnt[HW-1:0], pre_cnt};

  // R10: a disabled core holds both counters
  a_r10_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.enable && !main_load && !pre_load)
      |=> (main_cnt == $past(main_cnt) && pre_cnt == $past(pre_cnt)));

  // R8: a halted core without debug-run freezes
  a_r8_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_halt && !ctrl.dbg_run && !main_load && !pre_load)
      |=> (main_cnt == $past(main_cnt) && pre_cnt == $past(pre_cnt)));

  // R3: in match mode the main counter moves only on a pre-counter match
  a_r3_match_only: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.match_mode && !(run && pre_cnt == match_ref) && !main_load)
      |=> (main_cnt == $past(main_cnt)));

  // R9: written value appears regardless of counting
  a_r9_main_write: assert property (@(posedge clk) disable iff (!rst_n)
    main_load |=> (main_cnt == $past(wr_data)));

endmodule

// File: tb/sim_rtc_core.sv
`timescale 1ns/1ps
module sim_rtc_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic [14:0] match_ref = 15'd0;
  logic [31:0] wrap_ref = 32'd0;
  logic        dbg_halt = 1'b0;
  logic [14:0] pre_cnt;
  logic [31:0] main_cnt;
  logic [31:0] comb_view;
  logic        locked;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [31:0] ENGAGE  = 32'h4C4F_434B;
  localparam logic [31:0] RELEASE = 32'h554E_4C4B;

  always #4 clk = ~clk;

  rtc_core u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .match_ref(match_ref), .wrap_ref(wrap_ref),
    .dbg_halt(dbg_halt), .pre_cnt(pre_cnt), .main_cnt(main_cnt),
    .comb_view(comb_view), .locked(locked)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; the write lands at the following posedge
  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] cw(input bit en, input bit drun, input bit pw,
                                     input bit mw, input bit mm, input int n);
    return {20'd0, 4'(n), 3'd0, mm, mw, pw, drun, en};
  endfunction

  task automatic restart(input logic [31:0] c);
    wr(2'd0, 32'd0);
    wr(2'd1, 32'd0);
    wr(2'd2, 32'd0);
    wr(2'd0, c);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 main", main_cnt, 0);
    chk("R12 pre", {17'd0, pre_cnt}, 0);
    chk("R12 lock", {31'd0, locked}, 0);
    idle(4);
    chk("R12 idle hold", main_cnt, 0);

    // R1 / R2 sweep over every divider select
    for (int n = 0; n < 16; n++) begin
      int nn;
      nn = (1 << n) + 5;
      restart(cw(1, 0, 0, 0, 0, n));
      idle(nn);
      chk($sformatf("R1 div n=%0d", n), main_cnt, 32'(nn >> n));
      chk($sformatf("R2 pre n=%0d", n), {17'd0, pre_cnt}, 32'(nn % 32768));
    end

    // R11 select change clears divider
    restart(cw(1, 0, 0, 0, 0, 2));
    idle(2);
    wr(2'd0, cw(1, 0, 0, 0, 0, 3));
    idle(6);
    chk("R11 sel change early", main_cnt, 0);
    idle(2);
    chk("R11 sel change tick", main_cnt, 1);

    // R11 disable clears divider
    restart(cw(1, 0, 0, 0, 0, 2));
    idle(2);
    wr(2'd0, cw(0, 0, 0, 0, 0, 2));
    wr(2'd0, cw(1, 0, 0, 0, 0, 2));
    idle(2);
    chk("R11 disable clear", main_cnt, 0);
    idle(2);
    chk("R11 disable tick", main_cnt, 1);

    // R10 disabled hold
    wr(2'd0, cw(0, 0, 0, 0, 0, 0));
    begin
      logic [31:0] m; logic [14:0] p;
      m = main_cnt; p = pre_cnt;
      idle(9);
      chk("R10 main hold", main_cnt, m);
      chk("R10 pre hold", {17'd0, pre_cnt}, {17'd0, p});
    end

    // R3 / R4 match mode with pre-wrap at 4
    match_ref = 15'd4;
    restart(cw(1, 0, 1, 0, 1, 0));
    idle(23);
    chk("R3 match main", main_cnt, 23 / 5);
    chk("R4 pre wrap", {17'd0, pre_cnt}, 23 % 5);

    // R3 without pre-wrap: one step per 32768 cycles, first after 5
    match_ref = 15'd4;
    restart(cw(1, 0, 0, 0, 1, 0));
    idle(5);
    chk("R3 first match", main_cnt, 1);
    idle(40);
    chk("R3 no extra", main_cnt, 1);

    // R5 main wrap at 2
    wrap_ref = 32'd2;
    restart(cw(1, 0, 0, 1, 0, 0));
    idle(7);
    chk("R5 main wrap", main_cnt, 7 % 3);

    // R9 write priority while counting every cycle
    restart(cw(1, 0, 0, 0, 0, 0));
    idle(3);
    wr(2'd2, 32'd100);
    chk("R9 main write", main_cnt, 100);
    wr(2'd1, 32'd20);
    chk("R9 pre write", {17'd0, pre_cnt}, 20);
    chk("R9 main runs", main_cnt, 101);

    // R6 combined view
    wr(2'd0, cw(0, 0, 0, 0, 0, 0));
    wr(2'd2, 32'h0003_2345);
    wr(2'd1, 32'h0000_1ABC);
    chk("R6 comb", comb_view, (32'h0001_2345 << 15) | 32'h1ABC);

    // R8 debug halt
    dbg_halt = 1'b1;
    restart(cw(1, 0, 0, 0, 0, 0));
    idle(10);
    chk("R8 halt main", main_cnt, 0);
    chk("R8 halt pre", {17'd0, pre_cnt}, 0);
    wr(2'd0, cw(1, 1, 0, 0, 0, 0));
    idle(6);
    chk("R8 dbg run", main_cnt, 6);
    dbg_halt = 1'b0;

    // R7 lock
    wr(2'd0, cw(0, 0, 0, 0, 0, 0));
    wr(2'd2, 32'd7);
    wr(2'd1, 32'd3);
    wr(2'd3, ENGAGE);
    chk("R7 engaged", {31'd0, locked}, 1);
    wr(2'd2, 32'h55);
    wr(2'd1, 32'd9);
    wr(2'd0, cw(1, 0, 0, 0, 0, 0));
    idle(4);
    chk("R7 main ignored", main_cnt, 7);
    chk("R7 pre ignored", {17'd0, pre_cnt}, 3);
    wr(2'd3, 32'h1234);
    chk("R7 other key", {31'd0, locked}, 1);
    wr(2'd3, RELEASE);
    chk("R7 released", {31'd0, locked}, 0);
    wr(2'd2, 32'h55);
    chk("R7 write after release", main_cnt, 32'h55);
    wr(2'd3, 32'h1234);
    chk("R7 other key unlocked", {31'd0, locked}, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule